// File: doc/BRIEF.md
# Link Rate and Lane Count Selector

This block picks the number of DisplayPort main-link lanes and the per-lane link rate needed to carry a video mode. It takes a pixel clock in kHz, a colour depth in bits per component, the sink's advertised maximum rate and lane count, and a flag saying whether the link may use the 5.4 Gbit/s tier. It returns a lane count, a link rate in kHz and a flag that tells whether the mode can be driven at all.

The policy favours few lanes. The lane count is fixed first, against the highest rate the link allows. The lowest standard rate that still carries the mode on those lanes is then chosen. No divider is used: every capacity test compares `pixel clock x bpp` against `rate x lanes x 8` as wide unsigned products.

A caller presents the inputs and pulses `start` for one cycle. One cycle later the results are registered and `done` pulses. The results hold until the next `start`.

Top module: `link_cfg_sel`

## Requirements
- R1: Bits per pixel is 24 when `bitsPerColor` is 0, and three times `bitsPerColor` otherwise.
- R2: The usable maximum rate is `sinkRateKhz` capped at 540000 when `dp12Cap` is 1, and capped at 270000 when `dp12Cap` is 0.
- R3: The lane count is the first value in the sequence 1, 2, 4 that either is not below `sinkLaneMax` or satisfies `pixClkKhz*bpp <= maxRate*lanes*8`. It saturates at 4, so `laneCount` always has exactly one bit set.
- R4: With the chosen lanes, the rate is the first of 162000 and 270000 whose capacity covers the pixel clock. A capacity covers the pixel clock when `pixClkKhz*bpp <= rate*lanes*8`, and equality counts as a fit.
- R5: When neither 162000 nor 270000 fits, and 540000 is not allowed or does not fit either, the rate is the usable maximum rate from R2.
- R6: The rate 540000 is chosen by the ladder only when `dp12Cap` is 1. With `dp12Cap` at 0 the output rate is never 540000.
- R7: `modeOk` is 0 when `pixClkKhz` is above 340000 and `dp12Cap` is 0, or when the rate is 540000 and `dp12Cap` is 0. Otherwise it is 1.
- R8: The outputs take the result of the inputs sampled at a clock edge where `start` is 1. `done` is 1 during exactly the cycle after each such edge.
- R9: Between starts, `laneCount`, `linkRateKhz` and `modeOk` hold their values whatever the inputs do.
- R10: After reset, `laneCount`, `linkRateKhz`, `modeOk` and `done` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Sample the inputs and compute |
| pixClkKhz | input | 20 | Requested pixel clock, kHz |
| bitsPerColor | input | 4 | Bits per colour component, 0 means default |
| sinkRateKhz | input | 20 | Sink maximum link rate, kHz |
| sinkLaneMax | input | 3 | Sink maximum lane count |
| dp12Cap | input | 1 | Link may use the 5.4 Gbit/s rate |
| laneCount | output | 3 | Chosen lane count (1, 2 or 4) |
| linkRateKhz | output | 20 | Chosen link rate, kHz |
| modeOk | output | 1 | Mode can be driven |
| done | output | 1 | Result valid pulse |

## Verification
Every cycle, the assertions check the following:
- `done` tracks `start` with one cycle of delay.
- The results hold between starts.
- The lane count is one-hot.
- Without the capability flag, the rate never reaches 540000 and a pixel clock above 340000 is never flagged valid.

The choice of lane count and rate depends on arithmetic thresholds, so only the bench's sweep can show it. The sweep covers colour depths, sink limits and pixel clocks placed exactly on and just past the capacity boundaries. It compares each result against a separately computed loop model.

// File: rtl/link_cfg_pkg.sv
package link_cfg_pkg;
  typedef struct packed {
    logic capture;
  } selStrobe_t;
endpackage

// File: rtl/link_cfg_ctrl.sv
module link_cfg_ctrl
  import link_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  output selStrobe_t strobes,
  output logic       done
);
  always_comb strobes.capture = start;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) done <= 1'b0;
    else       done <= start;
  end

  assert_done_follows_R8: assert property (@(posedge clk) disable iff (!rstN)
    start |=> done);
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> !done);
endmodule

// File: rtl/link_cfg_dp.sv
module link_cfg_dp
  import link_cfg_pkg::*;
#(
  parameter int PCLK_W     = 20,
  parameter int BPC_W      = 4,
  parameter int RATE_W     = 20,
  parameter int LANE_W     = 3,
  parameter int RATE_LOW   = 162000,
  parameter int RATE_MID   = 270000,
  parameter int RATE_HIGH  = 540000,
  parameter int PCLK_LIMIT = 340000
) (
  input  logic              clk,
  input  logic              rstN,
  input  selStrobe_t        strobes,
  input  logic [PCLK_W-1:0] pixClkKhz,
  input  logic [BPC_W-1:0]  bitsPerColor,
  input  logic [RATE_W-1:0] sinkRateKhz,
  input  logic [LANE_W-1:0] sinkLaneMax,
  input  logic              dp12Cap,
  output logic [LANE_W-1:0] laneOut,
  output logic [RATE_W-1:0] rateOut,
  output logic              validOut
);
  localparam int BPP_W    = BPC_W + 2;
  localparam int LHS_W    = PCLK_W + BPP_W;
  localparam int RHS_W    = RATE_W + LANE_W + 3;
  localparam int PROD_W   = ((LHS_W > RHS_W) ? LHS_W : RHS_W) + 1;
  localparam int STEPS    = LANE_W;
  localparam logic [RATE_W-1:0] R_LOW  = RATE_W'(RATE_LOW);
  localparam logic [RATE_W-1:0] R_MID  = RATE_W'(RATE_MID);
  localparam logic [RATE_W-1:0] R_HIGH = RATE_W'(RATE_HIGH);
  localparam logic [LANE_W-1:0] TOP_LANE = LANE_W'(1) << (STEPS - 1);

  function automatic logic [PROD_W-1:0] capOf(input logic [RATE_W-1:0] r,
                                              input logic [LANE_W-1:0] l);
    capOf = PROD_W'(r) * PROD_W'(l) * PROD_W'(8);
  endfunction

  logic [BPP_W-1:0]  bpp;
  logic [PROD_W-1:0] demand;
  logic [RATE_W-1:0] capLimit, maxRate;
  logic [STEPS-1:0]  laneHit;
  logic [LANE_W-1:0] laneSel;
  logic [RATE_W-1:0] rateSel;
  logic              validSel;

  // R1: bits per pixel
  always_comb begin
    if (bitsPerColor == '0) bpp = BPP_W'(24);
    else                    bpp = BPP_W'(bitsPerColor) * BPP_W'(3);
  end

  assign demand = PROD_W'(pixClkKhz) * PROD_W'(bpp);

  // R2: capped maximum rate
  assign capLimit = dp12Cap ? R_HIGH : R_MID;
  assign maxRate  = (sinkRateKhz < capLimit) ? sinkRateKhz : capLimit;

  // R3: per-candidate stop condition for lane counts 1, 2, 4, ...
  for (genvar k = 0; k < STEPS; k++) begin : g_lane
    localparam logic [LANE_W-1:0] CAND = LANE_W'(1) << k;
    assign laneHit[k] = (CAND >= sinkLaneMax) || (demand <= capOf(maxRate, CAND));
  end

  always_comb begin
    laneSel = TOP_LANE;
    for (int k = STEPS - 1; k >= 0; k--) begin
      if (laneHit[k]) laneSel = LANE_W'(1) << k;
    end
  end

  // R4 / R5 / R6: rate ladder
  always_comb begin
    if (demand <= capOf(R_LOW, laneSel))                rateSel = R_LOW;
    else if (demand <= capOf(R_MID, laneSel))           rateSel = R_MID;
    else if (dp12Cap && demand <= capOf(R_HIGH, laneSel)) rateSel = R_HIGH;
    else                                                rateSel = maxRate;
  end

  // R7: validity
  assign validSel = !((pixClkKhz > PCLK_W'(PCLK_LIMIT)) && !dp12Cap) &&
                    !((rateSel == R_HIGH) && !dp12Cap);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      laneOut  <= '0;
      rateOut  <= '0;
      validOut <= 1'b0;
    end else if (strobes.capture) begin
      laneOut  <= laneSel;
      rateOut  <= rateSel;
      validOut <= validSel;
    end
  end

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capture |=> ($stable(laneOut) && $stable(rateOut) && $stable(validOut)));
  assert_lane_onehot_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |=> ($countones(laneOut) == 1));
  assert_no_high_rate_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capture && !dp12Cap) |=> (rateOut != R_HIGH));
  assert_pclk_limit_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capture && !dp12Cap && (pixClkKhz > PCLK_W'(PCLK_LIMIT))) |=> !validOut);
endmodule

// File: rtl/link_cfg_sel.sv
module link_cfg_sel
  import link_cfg_pkg::*;
#(
  parameter int PCLK_W = 20,
  parameter int BPC_W  = 4,
  parameter int RATE_W = 20,
  parameter int LANE_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [PCLK_W-1:0] pixClkKhz,
  input  logic [BPC_W-1:0]  bitsPerColor,
  input  logic [RATE_W-1:0] sinkRateKhz,
  input  logic [LANE_W-1:0] sinkLaneMax,
  input  logic              dp12Cap,
  output logic [LANE_W-1:0] laneCount,
  output logic [RATE_W-1:0] linkRateKhz,
  output logic              modeOk,
  output logic              done
);
  selStrobe_t strobes;

  link_cfg_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .strobes(strobes), .done(done)
  );

  link_cfg_dp #(
    .PCLK_W(PCLK_W), .BPC_W(BPC_W), .RATE_W(RATE_W), .LANE_W(LANE_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .pixClkKhz(pixClkKhz), .bitsPerColor(bitsPerColor),
    .sinkRateKhz(sinkRateKhz), .sinkLaneMax(sinkLaneMax), .dp12Cap(dp12Cap),
    .laneOut(laneCount), .rateOut(linkRateKhz), .validOut(modeOk)
  );
endmodule

// File: tb/tb_link_cfg_sel.sv
module tb_link_cfg_sel;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [19:0] pixClkKhz = '0;
  logic [3:0]  bitsPerColor = '0;
  logic [19:0] sinkRateKhz = '0;
  logic [2:0]  sinkLaneMax = '0;
  logic        dp12Cap = 1'b0;
  logic [2:0]  laneCount;
  logic [19:0] linkRateKhz;
  logic        modeOk;
  logic        done;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  link_cfg_sel dut (
    .clk(clk), .rstN(rstN), .start(start), .pixClkKhz(pixClkKhz),
    .bitsPerColor(bitsPerColor), .sinkRateKhz(sinkRateKhz),
    .sinkLaneMax(sinkLaneMax), .dp12Cap(dp12Cap), .laneCount(laneCount),
    .linkRateKhz(linkRateKhz), .modeOk(modeOk), .done(done)
  );

  task automatic check(input string req, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // independent loop model
  longint eLane, eRate;
  bit     eOk;
  task automatic model(input longint pix, input longint bpc, input longint sRate,
                       input longint sLanes, input bit cap);
    longint bpp, maxR, lane, need;
    bpp  = (bpc == 0) ? 24 : 3 * bpc;
    maxR = cap ? 540000 : 270000;
    if (sRate < maxR) maxR = sRate;
    need = pix * bpp;
    lane = 1;
    while (lane < sLanes && lane < 4) begin
      if (need <= maxR * lane * 8) break;
      lane = lane * 2;
    end
    if (need <= 162000 * lane * 8)              eRate = 162000;
    else if (need <= 270000 * lane * 8)         eRate = 270000;
    else if (cap && need <= 540000 * lane * 8)  eRate = 540000;
    else                                        eRate = maxR;
    eLane = lane;
    eOk = !((pix > 340000) && !cap) && !((eRate == 540000) && !cap);
  endtask

  task automatic runCase(input int pix, input int bpc, input int sRate,
                         input int sLanes, input bit cap);
    @(negedge clk);
    pixClkKhz = 20'(pix); bitsPerColor = 4'(bpc); sinkRateKhz = 20'(sRate);
    sinkLaneMax = 3'(sLanes); dp12Cap = cap; start = 1'b1;
    model(pix, bpc, sRate, sLanes, cap);
    @(negedge clk);
    start = 1'b0;
    check("R8 done after start", done, 1);
    check("R1 R3 lanes", laneCount, eLane);
    check("R2 R4 R5 rate", linkRateKhz, eRate);
    check("R7 modeOk", modeOk, eOk);
    if (!cap) check("R6 no 540000 without cap", linkRateKhz == 540000, 0);
    // R9: disturb inputs without start, results must hold
    pixClkKhz = 20'(pix ^ 20'h5a5a5); dp12Cap = ~cap; sinkLaneMax = 3'(sLanes + 1);
    @(negedge clk);
    check("R8 done single pulse", done, 0);
    check("R9 lanes hold", laneCount, eLane);
    check("R9 rate hold", linkRateKhz, eRate);
  endtask

  int pixList[14] = '{1000, 54000, 54001, 90000, 90001, 108000, 180000,
                      180001, 216000, 340000, 340001, 360000, 720000, 1000000};
  int bpcList[4]  = '{0, 6, 8, 10};
  int rateList[3] = '{162000, 270000, 540000};
  int laneList[4] = '{1, 2, 3, 4};

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 lanes reset", laneCount, 0);
    check("R10 rate reset", linkRateKhz, 0);
    check("R10 modeOk reset", modeOk, 0);
    check("R10 done reset", done, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R10 no done without start", done, 0);

    for (int c = 0; c < 2; c++)
      for (int b = 0; b < 4; b++)
        for (int r = 0; r < 3; r++)
          for (int l = 0; l < 4; l++)
            for (int p = 0; p < 14; p++)
              runCase(pixList[p], bpcList[b], rateList[r], laneList[l], c[0]);

    // R8: back-to-back starts keep done high and update each cycle
    @(negedge clk);
    pixClkKhz = 20'd54000; bitsPerColor = 4'd0; sinkRateKhz = 20'd270000;
    sinkLaneMax = 3'd4; dp12Cap = 1'b0; start = 1'b1;
    @(negedge clk);
    check("R8 back-to-back done", done, 1);
    check("R4 first of pair rate", linkRateKhz, 162000);
    pixClkKhz = 20'd54001;
    @(negedge clk);
    start = 1'b0;
    check("R8 back-to-back done 2", done, 1);
    check("R4 second of pair rate", linkRateKhz, 270000);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog R8 actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule